// File: doc/BRIEF.md
# Quadrature-anchored commutation decoder

This block recovers three commutation lines and an index pulse from a motor encoder that carries them as a time-multiplexed signal on one wire, next to a normal quadrature pair. The two quadrature inputs define four positional states. For each state the decoder keeps one memory bit, which is reloaded from the multiplexed line whenever the encoder sits in that state. The stored bits for three of the states form a three-bit key. Each valid key names one of six commutation sectors, and the decoder drives a six-step U/V/W code for that sector. The multiplexed line is high in the fourth state (both quadrature lines high) only while the index mark passes, so that condition drives the index output.

Because the memory follows position and not time, a change of direction leaves every stored bit valid. All three inputs are first brought onto the system clock through a synchronizer chain. A qualifier then lets a new sample through only when several consecutive samples agree, so short glitches never reach the state memory. The clock is expected to run many times faster than the fastest quadrature edge rate.

Top module: `quad_anchor_decoder`

## Requirements
- R1: With defaults (SYNC_STAGES=2, QUAL_DEPTH=2), a held input change first shows at the outputs after exactly SYNC_STAGES+QUAL_DEPTH+2 = 6 rising clock edges. After 5 edges the old values are still present.
- R2: A synchronized sample is accepted only when QUAL_DEPTH consecutive samples are equal on all three inputs. Otherwise the last accepted sample is kept. An input combination present for one clock cycle is ignored. One held for two cycles is accepted.
- R3: The state index is {A,B}. While an accepted sample is in state s, the memory bit of s takes the value of C. The bits of the other states keep their values.
- R4: Read as bits (state 00, state 01, state 10), the key selects one sector: 110 = C equals not A, 101 = not B, 001 = A and not B, 010 = B and not A, 100 = NOR, 011 = XOR.
- R5: The {U,V,W} codes for those six sectors, in the same order, are 001, 011, 010, 110, 100 and 101. Code 111 never appears.
- R6: Keys 000 and 111 match no sector, and {U,V,W} holds its previous value.
- R7: The index output is 1 exactly when the accepted sample has A=B=C=1 and the block is armed. It is 0 otherwise.
- R8: Reset clears all memory bits. U, V, W and the index stay 0 until each of the four states has been accepted at least once since reset (armed).
- R9: Walking the quadrature sequence in reverse gives the same sector as walking it forward for the same C function.
- R10: At most one sector matches in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a_i | input | 1 | Quadrature channel A, asynchronous |
| enc_b_i | input | 1 | Quadrature channel B, asynchronous |
| enc_mux_i | input | 1 | Multiplexed commutation/index line, asynchronous |
| hall_u_o | output | 1 | Commutation line U |
| hall_v_o | output | 1 | Commutation line V |
| hall_w_o | output | 1 | Commutation line W |
| index_o | output | 1 | Index pulse |

## Verification
The assertions check on every cycle that:
- the accepted sample holds whenever the qualifier sees disagreement;
- the state memory is frozen before the first accepted sample;
- at most one sector matches;
- an unmatched key holds the output code;
- outputs stay low while unarmed;
- the index output follows an A=B=C=1 sample two cycles earlier;
- code 111 never appears.

The bench sweeps all six sectors in both directions and all eight keys with the index state's C both low and high. Only these scenarios can show the exact sector codes, the latency in cycles, and that one-cycle glitches are rejected while two-cycle states are taken.

// File: rtl/qa_pkg.sv
package qa_pkg;

  localparam int NUM_STATES   = 4;
  localparam int NUM_PATTERNS = 6;
  localparam int CODE_W       = 3;

  typedef struct packed {
    logic a;
    logic b;
    logic c;
  } enc_sample_t;

  // Sector key: stored C for states {AB=00, AB=01, AB=10}, MSB first.
  function automatic logic [2:0] pattern_key(input int idx);
    logic [2:0] k;
    case (idx)
      0:       k = 3'b110;  // not A
      1:       k = 3'b101;  // not B
      2:       k = 3'b001;  // A and not B
      3:       k = 3'b010;  // B and not A
      4:       k = 3'b100;  // NOR
      default: k = 3'b011;  // XOR
    endcase
    return k;
  endfunction

  // Six-step {U,V,W} code, neighbours differ in one bit.
  function automatic logic [CODE_W-1:0] pattern_code(input int idx);
    logic [CODE_W-1:0] c;
    case (idx)
      0:       c = 3'b001;
      1:       c = 3'b011;
      2:       c = 3'b010;
      3:       c = 3'b110;
      4:       c = 3'b100;
      default: c = 3'b101;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/qa_input_qual.sv
module qa_input_qual
  import qa_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_DEPTH  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  enc_sample_t raw_i,
  output enc_sample_t acc_o,
  output logic        acc_vld_o,
  output logic        agree_o
);

  localparam int HIST = QUAL_DEPTH - 1;
  localparam int FILL = SYNC_STAGES + HIST;

  enc_sample_t       sync_q [SYNC_STAGES];
  enc_sample_t       hist_q [HIST];
  logic [FILL-1:0]   fill_q;
  enc_sample_t       sync_out;
  logic              agree;

  assign sync_out = sync_q[SYNC_STAGES-1];

  // All held history entries must equal the newest synchronized sample.
  always_comb begin
    agree = 1'b1;
    for (int k = 0; k < HIST; k++) begin
      if (hist_q[k] != sync_out) agree = 1'b0;
    end
  end

  assign agree_o = agree;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < SYNC_STAGES; k++) sync_q[k] <= '0;
      for (int k = 0; k < HIST; k++)        hist_q[k] <= '0;
      fill_q    <= '0;
      acc_o     <= '0;
      acc_vld_o <= 1'b0;
    end else begin
      sync_q[0] <= raw_i;
      for (int k = 1; k < SYNC_STAGES; k++) sync_q[k] <= sync_q[k-1];
      hist_q[0] <= sync_out;
      for (int k = 1; k < HIST; k++)        hist_q[k] <= hist_q[k-1];
      fill_q <= {fill_q[FILL-2:0], 1'b1};
      if (agree && fill_q[FILL-1]) begin
        acc_o     <= sync_out;
        acc_vld_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/qa_phase_store.sv
module qa_phase_store
  import qa_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  enc_sample_t           acc_i,
  input  logic                  acc_vld_i,
  output logic [NUM_STATES-1:0] st_bits_o,
  output logic                  armed_o,
  output logic                  z_pre_o
);

  localparam int STATE_W = $clog2(NUM_STATES);

  logic [STATE_W-1:0]    cur_state;
  logic [NUM_STATES-1:0] visited;

  assign cur_state = {acc_i.a, acc_i.b};

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_state
    logic bit_q;
    logic vis_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        bit_q <= 1'b0;
        vis_q <= 1'b0;
      end else if (acc_vld_i && (cur_state == STATE_W'(g))) begin
        bit_q <= acc_i.c;
        vis_q <= 1'b1;
      end
    end
    assign st_bits_o[g] = bit_q;
    assign visited[g]   = vis_q;
  end

  assign armed_o = &visited;

  always_ff @(posedge clk) begin
    if (rst) z_pre_o <= 1'b0;
    else     z_pre_o <= acc_vld_i & acc_i.a & acc_i.b & acc_i.c;
  end

endmodule

// File: rtl/qa_pattern_out.sv
module qa_pattern_out
  import qa_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_STATES-1:0]   st_bits_i,
  input  logic                    armed_i,
  input  logic                    z_pre_i,
  output logic [NUM_PATTERNS-1:0] hit_o,
  output logic [CODE_W-1:0]       uvw_o,
  output logic                    z_o
);

  logic [2:0]        key;
  logic [CODE_W-1:0] code;

  assign key = {st_bits_i[0], st_bits_i[1], st_bits_i[2]};

  for (genvar p = 0; p < NUM_PATTERNS; p++) begin : g_pat
    localparam logic [2:0] KEY = pattern_key(p);
    assign hit_o[p] = &(key ~^ KEY);
  end

  always_comb begin
    code = '0;
    for (int p = 0; p < NUM_PATTERNS; p++) begin
      if (hit_o[p]) code = code | pattern_code(p);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uvw_o <= '0;
      z_o   <= 1'b0;
    end else begin
      if (!armed_i)    uvw_o <= '0;
      else if (|hit_o) uvw_o <= code;
      z_o <= armed_i & z_pre_i;
    end
  end

endmodule

// File: rtl/quad_anchor_decoder.sv
module quad_anchor_decoder
  import qa_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_DEPTH  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic enc_a_i,
  input  logic enc_b_i,
  input  logic enc_mux_i,
  output logic hall_u_o,
  output logic hall_v_o,
  output logic hall_w_o,
  output logic index_o
);

  enc_sample_t             raw;
  enc_sample_t             q_acc;
  logic                    q_acc_vld;
  logic                    q_agree;
  logic [NUM_STATES-1:0]   st_bits;
  logic                    armed;
  logic                    z_pre;
  logic [NUM_PATTERNS-1:0] hit;
  logic [CODE_W-1:0]       uvw;

  assign raw = '{a: enc_a_i, b: enc_b_i, c: enc_mux_i};

  qa_input_qual #(
    .SYNC_STAGES (SYNC_STAGES),
    .QUAL_DEPTH  (QUAL_DEPTH)
  ) i_qual (
    .clk       (clk),
    .rst       (rst),
    .raw_i     (raw),
    .acc_o     (q_acc),
    .acc_vld_o (q_acc_vld),
    .agree_o   (q_agree)
  );

  qa_phase_store i_store (
    .clk       (clk),
    .rst       (rst),
    .acc_i     (q_acc),
    .acc_vld_i (q_acc_vld),
    .st_bits_o (st_bits),
    .armed_o   (armed),
    .z_pre_o   (z_pre)
  );

  qa_pattern_out i_out (
    .clk       (clk),
    .rst       (rst),
    .st_bits_i (st_bits),
    .armed_i   (armed),
    .z_pre_i   (z_pre),
    .hit_o     (hit),
    .uvw_o     (uvw),
    .z_o       (index_o)
  );

  assign {hall_u_o, hall_v_o, hall_w_o} = uvw;

endmodule

// File: rtl/qa_checker.sv
module qa_checker (
  input logic       clk,
  input logic       rst,
  input logic       agree,
  input logic [2:0] acc,
  input logic       acc_vld,
  input logic [3:0] st_bits,
  input logic       armed,
  input logic [5:0] hit,
  input logic       u,
  input logic       v,
  input logic       w,
  input logic       z
);

  // R2
  qual_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !agree |=> $stable(acc));

  // R3
  store_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_vld |=> $stable(st_bits));

  // R10
  single_hit_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));

  // R6
  unmatched_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && hit == 6'b0) |=> $stable({u, v, w}));

  // R8
  unarmed_low_chk: assert property (@(posedge clk) disable iff (rst)
    !armed |=> ({u, v, w, z} == 4'b0000));

  // R7
  index_src_chk: assert property (@(posedge clk) disable iff (rst)
    z |-> $past(acc_vld && acc == 3'b111, 2));

  // R5
  no_code7_chk: assert property (@(posedge clk) disable iff (rst)
    !(u && v && w));

endmodule

bind quad_anchor_decoder qa_checker i_qa_checker (
  .clk     (clk),
  .rst     (rst),
  .agree   (q_agree),
  .acc     (q_acc),
  .acc_vld (q_acc_vld),
  .st_bits (st_bits),
  .armed   (armed),
  .hit     (hit),
  .u       (hall_u_o),
  .v       (hall_v_o),
  .w       (hall_w_o),
  .z       (index_o)
);

// File: tb/test_quad_anchor_decoder.sv
module test_quad_anchor_decoder;

  localparam int LAT  = 6;
  localparam int HOLD = 10;

  logic clk = 1'b0;
  logic rst;
  logic a_d, b_d, c_d;
  logic u, v, w, z;

  int n_vec = 0;
  int n_bad = 0;

  // Bench model state
  logic [3:0] mem_m;
  logic [3:0] vis_m;
  logic [2:0] uvw_m;
  logic       z_m;

  always #2 clk = ~clk;

  quad_anchor_decoder i_quad_anchor_decoder (
    .clk       (clk),
    .rst       (rst),
    .enc_a_i   (a_d),
    .enc_b_i   (b_d),
    .enc_mux_i (c_d),
    .hall_u_o  (u),
    .hall_v_o  (v),
    .hall_w_o  (w),
    .index_o   (z)
  );

  // C as a function of A,B for each sector (R4 order).
  function automatic logic pat_fn(input int p, input logic a, input logic b);
    case (p)
      0:       return ~a;
      1:       return ~b;
      2:       return a & ~b;
      3:       return b & ~a;
      4:       return ~(a | b);
      default: return a ^ b;
    endcase
  endfunction

  function automatic logic [2:0] code_tbl(input int p);
    case (p)
      0:       return 3'b001;
      1:       return 3'b011;
      2:       return 3'b010;
      3:       return 3'b110;
      4:       return 3'b100;
      default: return 3'b101;
    endcase
  endfunction

  task automatic model_update(input logic a, input logic b, input logic c);
    logic [2:0] key;
    mem_m[{a, b}] = c;
    vis_m[{a, b}] = 1'b1;
    if (&vis_m) begin
      key = {mem_m[0], mem_m[1], mem_m[2]};
      for (int p = 0; p < 6; p++) begin
        if (key == {pat_fn(p, 1'b0, 1'b0), pat_fn(p, 1'b0, 1'b1), pat_fn(p, 1'b1, 1'b0)})
          uvw_m = code_tbl(p);
      end
      z_m = a & b & c;
    end else begin
      uvw_m = 3'b000;
      z_m   = 1'b0;
    end
  endtask

  task automatic check(input string tag);
    n_vec++;
    if ({u, v, w, z} !== {uvw_m, z_m}) begin
      n_bad++;
      $display("FAIL %s: uvw=%b z=%b, expected uvw=%b z=%b", tag, {u, v, w}, z, uvw_m, z_m);
    end
  endtask

  task automatic check_z(input string tag, input logic exp);
    n_vec++;
    if (z !== exp) begin
      n_bad++;
      $display("FAIL %s: z=%b, expected z=%b", tag, z, exp);
    end
  endtask

  task automatic step(input logic a, input logic b, input logic c, input string tag);
    @(negedge clk);
    a_d = a; b_d = b; c_d = c;
    model_update(a, b, c);
    repeat (HOLD) @(negedge clk);
    check(tag);
  endtask

  // Apply without checking; model follows only if held long enough (R2).
  task automatic brief(input logic a, input logic b, input logic c, input int cyc);
    @(negedge clk);
    a_d = a; b_d = b; c_d = c;
    if (cyc >= 2) model_update(a, b, c);
    repeat (cyc - 1) @(negedge clk);
  endtask

  task automatic walk(input int p, input bit rev, input int n, input string tag);
    logic [1:0] seq [4];
    seq[0] = 2'b00; seq[1] = 2'b01; seq[2] = 2'b11; seq[3] = 2'b10;
    for (int i = 0; i < n; i++) begin
      int idx;
      logic sa, sb;
      idx = rev ? (3 - (i % 4)) : (i % 4);
      {sa, sb} = seq[idx];
      step(sa, sb, pat_fn(p, sa, sb), tag);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL R1 watchdog: run not done, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    a_d = 1'b0; b_d = 1'b0; c_d = 1'b0;
    mem_m = '0; vis_m = '0; uvw_m = '0; z_m = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 reset state");
    rst = 1'b0;
    @(negedge clk);
    check("R8 after reset release");

    // Arming: three states visited, outputs still low; fourth arms.
    step(1'b0, 1'b0, 1'b1, "R8 unarmed 00");
    step(1'b0, 1'b1, 1'b1, "R8 unarmed 01");
    step(1'b1, 1'b0, 1'b0, "R8 unarmed 10");
    step(1'b1, 1'b1, 1'b0, "R8 armed not-A sector");

    // Every sector both directions.
    for (int p = 0; p < 6; p++) begin
      walk(p, 1'b0, 6, "R4 R5 R10 forward");
      walk(p, 1'b1, 6, "R9 reverse");
    end

    // All eight keys, index-state C low and high.
    for (int k = 0; k < 8; k++) begin
      for (int zc = 0; zc < 2; zc++) begin
        logic [2:0] kk;
        kk = 3'(k);
        step(1'b0, 1'b0, kk[2], "R3 R6 key sweep");
        step(1'b0, 1'b1, kk[1], "R3 R6 key sweep");
        step(1'b1, 1'b0, kk[0], "R3 R6 key sweep");
        step(1'b1, 1'b1, 1'(zc), "R7 index state");
      end
    end

    // Exact latency on the index output.
    walk(1, 1'b0, 4, "R4 setup not-B");
    step(1'b1, 1'b0, pat_fn(1, 1'b1, 1'b0), "R7 pre-latency");
    @(negedge clk);
    a_d = 1'b1; b_d = 1'b1; c_d = 1'b1;
    model_update(1'b1, 1'b1, 1'b1);
    repeat (LAT - 1) @(negedge clk);
    check_z("R1 edge 5 old value", 1'b0);
    @(negedge clk);
    check_z("R1 edge 6 new value", 1'b1);
    repeat (HOLD) @(negedge clk);
    check("R7 index held");

    // Glitch rejection.
    walk(3, 1'b0, 4, "R4 setup B-not-A");
    step(1'b1, 1'b0, 1'b0, "R2 setup state 10");
    brief(1'b0, 1'b0, 1'b1, 1);
    step(1'b0, 1'b1, 1'b1, "R2 one-cycle state ignored");
    brief(1'b0, 1'b0, 1'b1, 2);
    step(1'b0, 1'b1, 1'b1, "R2 two-cycle state accepted");
    brief(1'b0, 1'b1, 1'b0, 1);
    step(1'b0, 1'b1, 1'b1, "R2 R3 one-cycle C glitch ignored");

    finish_run();
  end

endmodule